// File: doc/BRIEF.md
# ADC power sequencing controller

This block manages power for an ADC made of two converters, A and B. A 16-bit control and status word holds a power-down bit for each converter, two automatic modes (auto-standby and auto-powerdown) and a 6-bit power-up delay counted in ADC clocks. When a converter is powered up by hand, the block counts the delay on a counter owned by that converter. It reports the converter as powered down until that count ends. Scan requests are held until every running delay has ended, and each is answered with a one-cycle grant.

In auto-standby the converters sit in low-current standby with the slow standby clock selected while no scan is in progress. A request switches to the conversion clock, waits the programmed delay and then grants the scan. A scan-done pulse drops the block back to standby. In auto-powerdown the enabled converters stay off while idle. They are switched on by a request, granted after the delay, and switched off again on scan-done. Auto-powerdown overrides auto-standby. The converters themselves and the glitch-free clock switch are outside this block. The block drives only the select, the current-mode and the power-enable lines.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the word reads 0x1DA7: both converters powered down with status 1, delay 26, both automatic modes off. `pwr_en` is 00, `clk_sel_conv` is 1 and `standby_cur` is 0.
- R2: Bits 14 and 13 always read 0, and bits 12 and 2 always read 1, whatever is written.
- R3: A write stores bit 15 (auto-standby), bits 9:4 (delay), bit 3 (auto-powerdown), bit 1 (power-down B) and bit 0 (power-down A), and these read back. Bits 11 and 10 are status bits and ignore written values.
- R4: Writing 1 to a power-down bit makes the matching status bit (11 for B, 10 for A) read 1 in the cycle after the write edge, and that converter's `pwr_en` (bit 1 for B, bit 0 for A) drops at the same time.
- R5: With auto-powerdown off, writing 0 to a set power-down bit raises `pwr_en` at once. The status bit clears exactly D clocks after the write edge, where D is the delay. The two converters count independently.
- R6: Writing 1 to a power-down bit while its delay count runs aborts the count, and the status bit stays 1.
- R7: A scan request made while any converter delay count runs is held, not dropped. It is granted in the cycle after the last count ends. With no count running and no automatic mode, the grant follows the request edge directly.
- R8: In auto-standby (bit 15 = 1, bit 3 = 0) while idle, `clk_sel_conv` is 0 (standby clock) and `standby_cur` is 1.
- R9: In auto-standby, a request switches `clk_sel_conv` to 1 and clears `standby_cur` right after the request edge. The grant follows D clocks later. After the scan-done edge, the standby clock and standby current return.
- R10: With auto-powerdown on, auto-standby has no effect: `clk_sel_conv` stays 1 and `standby_cur` stays 0.
- R11: In auto-powerdown, idle converters have `pwr_en` 0 and status 1. A request powers up the converters whose power-down bit is 0, and their status reads 0. The grant follows D clocks after the request edge, and scan-done powers them down again.
- R12: The grant is a one-cycle pulse and only one scan is active at a time. A request arriving during an active scan is granted in the cycle after the scan-done edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control/status word |
| scan_req | input | 1 | One-cycle scan request |
| scan_done | input | 1 | One-cycle pulse, converter has returned to idle |
| scan_grant | output | 1 | One-cycle permission to start the scan |
| clk_sel_conv | output | 1 | 1 selects the conversion clock, 0 the standby clock |
| standby_cur | output | 1 | Converters in standby current mode |
| pwr_en | output | 2 | Power enable, bit 0 converter A, bit 1 converter B |

## Verification
Some properties are checked on every cycle:
- the fixed read-only bits;
- a status bit setting right after a power-down write;
- an abort clearing the delay counter;
- single-cycle grants that never come while a delay count was running;
- a request never being lost, since it is either granted or held pending;
- auto-powerdown dropping power after scan-done.

The exact delay lengths need the bench's scenarios:
- status clearing on the D-th clock;
- a grant held until the cycle after a count ends;
- the auto-standby clock and current switching around a scan;
- independent overlapping power-ups of A and B.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  localparam int REG_W    = 16;
  localparam int NCONV    = 2;
  // bit positions of the control/status word
  localparam int B_ASB    = 15;
  localparam int B_ZERO_HI = 14;
  localparam int B_ZERO_LO = 13;
  localparam int B_ONE_HI = 12;
  localparam int B_STAT_LO = 10;
  localparam int B_DLY_LO = 4;
  localparam int B_APD    = 3;
  localparam int B_ONE_LO = 2;
  localparam int B_PD_LO  = 0;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAKE = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_pwr_dly_ctr.sv
module adc_pwr_dly_ctr #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic [DLY_W-1:0] dly,
  output logic             busy
);
  localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= (dly != '0);
      cnt_q <= dly;
    end else if (busy) begin
      if (cnt_q <= CNT_ONE) busy <= 1'b0;
      cnt_q <= cnt_q - CNT_ONE;
    end
  end

  // R6: an abort always leaves the counter idle
  a_r6_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
  // R5: a start with a nonzero delay always makes the counter busy
  a_r5_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !abort && dly != '0) |=> busy);
endmodule

// File: rtl/adc_pwr_scan_fsm.sv
module adc_pwr_scan_fsm
  import adc_pwr_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_mode,
  input  logic [DLY_W-1:0] dly,
  input  logic             hold,
  input  logic             scan_req,
  input  logic             scan_done,
  output seq_state_e       state,
  output logic             scan_grant
);
  localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;
  logic             pend_q;
  logic             req_any;

  assign req_any = pend_q | scan_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      scan_grant <= 1'b0;
    end else begin
      scan_grant <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (req_any && !hold) begin
            if (auto_mode && dly != '0) begin
              state  <= SEQ_WAKE;
              cnt_q  <= dly;
              pend_q <= 1'b1;
            end else begin
              state      <= SEQ_RUN;
              scan_grant <= 1'b1;
              pend_q     <= pend_q & scan_req;
            end
          end else begin
            pend_q <= req_any;
          end
        end
        SEQ_WAKE: begin
          if (cnt_q > CNT_ONE) begin
            cnt_q  <= cnt_q - CNT_ONE;
            pend_q <= 1'b1;
          end else if (!hold) begin
            state      <= SEQ_RUN;
            scan_grant <= 1'b1;
            pend_q     <= scan_req;
          end
        end
        SEQ_RUN: begin
          pend_q <= req_any;
          if (scan_done) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R12: a grant lasts one cycle
  a_r12_grant_pulse: assert property (@(posedge clk) disable iff (rst)
    scan_grant |=> !scan_grant);
  // R7: a request is granted or kept pending, never dropped
  a_r7_req_kept: assert property (@(posedge clk) disable iff (rst)
    scan_req |=> (pend_q || scan_grant));
  // R9: no grant while the wake count still has more than one clock to go
  a_r9_wake_wait: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_WAKE && cnt_q > CNT_ONE) |=> !scan_grant);
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int DLY_W   = 6,
  parameter int DLY_RST = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             scan_req,
  input  logic             scan_done,
  output logic             scan_grant,
  output logic             clk_sel_conv,
  output logic             standby_cur,
  output logic [NCONV-1:0] pwr_en
);
  logic             asb_q;
  logic             apd_q;
  logic [DLY_W-1:0] dly_q;
  logic [NCONV-1:0] pd_q;
  logic [NCONV-1:0] start;
  logic [NCONV-1:0] abort;
  logic [NCONV-1:0] busy;
  logic [NCONV-1:0] stat;
  logic             asb_eff;
  logic             active;
  seq_state_e       state;
  logic             unused_wr;

  assign unused_wr = ^{wr_data[B_ZERO_HI:B_STAT_LO], wr_data[B_ONE_LO]};

  // configuration register
  always_ff @(posedge clk) begin
    if (rst) begin
      asb_q <= 1'b0;
      apd_q <= 1'b0;
      dly_q <= DLY_W'(DLY_RST);
      pd_q  <= '1;
    end else if (wr_en) begin
      asb_q <= wr_data[B_ASB];
      apd_q <= wr_data[B_APD];
      dly_q <= wr_data[B_DLY_LO +: DLY_W];
      pd_q  <= wr_data[B_PD_LO +: NCONV];
    end
  end

  assign active  = (state != SEQ_IDLE);
  assign asb_eff = asb_q & ~apd_q;

  for (genvar i = 0; i < NCONV; i++) begin : g_conv
    assign start[i] = wr_en && pd_q[i] && !wr_data[B_PD_LO+i] && !wr_data[B_APD];
    assign abort[i] = wr_en && wr_data[B_PD_LO+i];

    adc_pwr_dly_ctr #(.DLY_W(DLY_W)) i_ctr (
      .clk   (clk),
      .rst   (rst),
      .start (start[i]),
      .abort (abort[i]),
      .dly   (wr_data[B_DLY_LO +: DLY_W]),
      .busy  (busy[i])
    );

    assign pwr_en[i] = apd_q ? (~pd_q[i] & active) : ~pd_q[i];
    assign stat[i]   = apd_q ? ~pwr_en[i] : (pd_q[i] | busy[i]);

    // R4: status reads powered-down right after a power-down write
    a_r4_stat_set: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[B_PD_LO+i]) |=> rd_data[B_STAT_LO+i]);
  end

  adc_pwr_scan_fsm #(.DLY_W(DLY_W)) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .auto_mode  (asb_q | apd_q),
    .dly        (dly_q),
    .hold       (|busy),
    .scan_req   (scan_req),
    .scan_done  (scan_done),
    .state      (state),
    .scan_grant (scan_grant)
  );

  assign clk_sel_conv = asb_eff ? active : 1'b1;
  assign standby_cur  = asb_eff & ~active;

  always_comb begin
    rd_data                      = '0;
    rd_data[B_ASB]               = asb_q;
    rd_data[B_ONE_HI]            = 1'b1;
    rd_data[B_STAT_LO +: NCONV]  = stat;
    rd_data[B_DLY_LO +: DLY_W]   = dly_q;
    rd_data[B_APD]               = apd_q;
    rd_data[B_ONE_LO]            = 1'b1;
    rd_data[B_PD_LO +: NCONV]    = pd_q;
  end

  // R2: fixed read-only bits
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_ZERO_HI:B_ZERO_LO] == 2'b00) && rd_data[B_ONE_HI] && rd_data[B_ONE_LO]);
  // R7: never grant while a converter delay count was running
  a_r7_grant_ready: assert property (@(posedge clk) disable iff (rst)
    scan_grant |-> ($past(busy) == '0));
  // R11: auto-powerdown removes power after scan-done
  a_r11_apd_off: assert property (@(posedge clk) disable iff (rst)
    (apd_q && scan_done && state == SEQ_RUN && !wr_en) |=> (pwr_en == '0));
  // R10: no standby clock or current while auto-powerdown is on
  a_r10_apd_wins: assert property (@(posedge clk) disable iff (rst)
    apd_q |-> (clk_sel_conv && !standby_cur));
endmodule

// File: tb/test_adc_pwr_seq.sv
`timescale 1ns/1ps
module test_adc_pwr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        scan_req = 1'b0;
  logic        scan_done = 1'b0;
  logic        scan_grant;
  logic        clk_sel_conv;
  logic        standby_cur;
  logic [1:0]  pwr_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_pwr_seq i_adc_pwr_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .scan_req(scan_req), .scan_done(scan_done), .scan_grant(scan_grant),
    .clk_sel_conv(clk_sel_conv), .standby_cur(standby_cur), .pwr_en(pwr_en)
  );

  function automatic logic [15:0] mk(bit asb, bit apd, int d, bit [1:0] pd);
    logic [5:0] d6 = d[5:0];
    return {asb, 5'b0, d6, apd, 1'b0, pd};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // lat: clocks from the request edge to the grant edge
  task automatic req(int lat, bit push);
    if (push) exp_q.push_back(cyc + 1 + lat);
    scan_req = 1'b1;
    @(negedge clk);
    scan_req = 1'b0;
  endtask

  task automatic done();
    scan_done = 1'b1;
    @(negedge clk);
    scan_done = 1'b0;
  endtask

  task automatic wait_grants();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: each grant must match the next expected edge
  always @(negedge clk) begin
    if (!rst && scan_grant) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7/R12: unexpected grant at cycle %0d, expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R7/R9/R11/R12: grant at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 word", rd_data, 16'h1DA7);
    chk("R1 pwr_en", {14'b0, pwr_en}, 16'h0);
    chk("R1 clock/current", {14'b0, clk_sel_conv, standby_cur}, 16'h2);

    // R2 R3 all ones, then all zeros (D=0 clears status at once)
    wr(16'hFFFF);
    chk("R2 R3 all ones", rd_data, 16'h9FFF);
    wr(16'h0000);
    chk("R2 R3 all zeros", rd_data, 16'h1004);
    chk("R3 pwr_en up", {14'b0, pwr_en}, 16'h3);

    // R4 power down A
    wr(mk(0, 0, 4, 2'b01));
    chk("R4 word", rd_data, 16'h1445);
    chk("R4 pwr_en", {14'b0, pwr_en}, 16'h2);

    // R5 power up A with D=4
    wr(mk(0, 0, 4, 2'b00));
    chk("R5 pwr_en at once", {14'b0, pwr_en}, 16'h3);
    idle(3);
    chk("R5 status still set", {14'b0, rd_data[11:10]}, 16'h1);
    idle(1);
    chk("R5 status cleared at D", {14'b0, rd_data[11:10]}, 16'h0);

    // R5 independent overlapping counts
    wr(mk(0, 0, 4, 2'b11));
    wr(mk(0, 0, 4, 2'b01));
    idle(1);
    wr(mk(0, 0, 4, 2'b00));
    idle(2);
    chk("R5 B done, A counting", {14'b0, rd_data[11:10]}, 16'h1);
    idle(2);
    chk("R5 A done", {14'b0, rd_data[11:10]}, 16'h0);

    // R6 abort during count
    wr(mk(0, 0, 4, 2'b11));
    wr(mk(0, 0, 4, 2'b10));
    idle(1);
    wr(mk(0, 0, 4, 2'b11));
    idle(6);
    chk("R6 status stays", {14'b0, rd_data[11:10]}, 16'h3);
    chk("R6 pwr_en off", {14'b0, pwr_en}, 16'h0);

    // R7 request held during counts
    wr(mk(0, 0, 4, 2'b00));
    req(4, 1);
    wait_grants();
    idle(1);
    done();
    // R7 direct grant
    req(0, 1);
    wait_grants();
    // R12 request during active scan
    req(0, 0);
    idle(3);
    exp_q.push_back(cyc + 2);
    done();
    wait_grants();
    done();
    chk("R12 queue drained", 16'(exp_q.size()), 16'h0);

    // R8 auto-standby idle
    wr(mk(1, 0, 4, 2'b00));
    chk("R8 standby clock/current", {14'b0, clk_sel_conv, standby_cur}, 16'h1);
    // R9 auto-standby scan
    req(4, 1);
    chk("R9 conversion clock", {14'b0, clk_sel_conv, standby_cur}, 16'h2);
    wait_grants();
    done();
    chk("R9 back to standby", {14'b0, clk_sel_conv, standby_cur}, 16'h1);

    // R10 R11 auto-powerdown overrides
    wr(mk(1, 1, 4, 2'b00));
    chk("R10 no standby", {14'b0, clk_sel_conv, standby_cur}, 16'h2);
    chk("R11 idle off", {12'b0, rd_data[11:10], pwr_en}, 16'hC);
    req(4, 1);
    chk("R11 powered for scan", {12'b0, rd_data[11:10], pwr_en}, 16'h3);
    wait_grants();
    done();
    chk("R11 off after done", {12'b0, rd_data[11:10], pwr_en}, 16'hC);
    chk("R10 still conversion clock", {14'b0, clk_sel_conv, standby_cur}, 16'h2);

    idle(3);
    chk("R12 no stray grants", 16'(exp_q.size()), 16'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule